// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is the master side of single-beat reads and writes on an external bus whose slaves answer with a transfer acknowledge. The core presents one request, and the block runs the whole bus cycle for it. The request carries a direction, an address, attribute bits, write data and a region index. During the cycle the block drives a bus clock, a transfer-start strobe, an address strobe, the address, the attributes, a read/write line and the write data. For a read it captures the returned data.

The block runs from a system clock at twice the bus clock rate. Each system clock is one half-phase state: the high phase of a bus clock, then its low phase. A cycle has three parts. First comes an address clock. Then comes a data clock, which repeats for every wait state. Last comes a hold clock, which keeps address and data stable in the slot that would otherwise be idle.

For each region, a configuration bit chooses where the acknowledge comes from. It is either the external slave, or an internal counter that is loaded with that region's 4-bit wait-state count.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and until the first request is taken, the outputs are idle: bus_ts_n=1, bus_as_n=1, bus_data_oe=0, core_done=0 and bus_rnw=1.
- R2: bus_clk alternates on every system clock, with one high phase and one low phase per bus clock. A taken request always starts its cycle in a high phase.
- R3: bus_ts_n is low for exactly the first bus clock of a cycle. Address, attributes and bus_rnw (1 = read, 0 = write) take the request's values at that same point.
- R4: bus_as_n falls at the low phase of the first bus clock. It stays low through every data clock and rises at the start of the hold clock.
- R5: A cycle with no wait states lasts three bus clocks. core_done is high for the high phase of the hold clock only. For a read, core_rdata then shows the bus_rdata sampled at the rising edge that ends the last data clock.
- R6: For a region whose acknowledge is external, bus_ta_n is sampled at the end of each data clock. Each sample found high adds one more data clock.
- R7: For a region whose acknowledge is internal, the count W in cfg_wait bits [4r+3:4r] adds exactly W data clocks, for W from 0 to 15. bus_ta_n has no effect on such a region. cfg_int_ack bit r = 1 selects internal acknowledge.
- R8: On a write, bus_data_oe is high and bus_wdata holds the request data from the start of the first data clock to the end of the hold clock. On a read, bus_data_oe stays low.
- R9: Address, attributes and bus_rnw stay unchanged from the start of the cycle to the end of the hold clock.
- R10: A request present in the low phase of the hold clock is taken there. The next cycle then starts in the very next high phase, with no idle bus clock between the two cycles.
- R11: core_busy is high from the high phase that starts a cycle through the high phase of the hold clock. It is also high in the high phases of idle. A request is taken only on a system clock where core_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_attr | input | TW | Request attributes |
| req_wdata | input | DW | Write data |
| req_region | input | RW | Region index selecting the acknowledge configuration |
| cfg_int_ack | input | NREG | Per-region internal acknowledge enable |
| cfg_wait | input | NREG*WW | Per-region wait-state counts |
| core_busy | output | 1 | Request cannot be taken this system clock |
| core_done | output | 1 | Cycle completion pulse in the hold clock |
| core_rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Bus clock, high in even states |
| bus_ts_n | output | 1 | Transfer-start strobe, active low |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rnw | output | 1 | Bus direction, 1 = read |
| bus_addr | output | AW | Bus address |
| bus_attr | output | TW | Bus attributes |
| bus_wdata | output | DW | Bus write data |
| bus_data_oe | output | 1 | Write data output enable |
| bus_rdata | input | DW | Bus read data |
| bus_ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
Two events can land in the same system clock: the end of a cycle's hold clock and the acceptance of the next request. The stimulus vectors are issued back to back, so each new request is already waiting while the previous cycle holds. A second such pair is also run in a directed test. The bench checks three things at that boundary. No wait is recorded before the new cycle is taken. The new transfer-start strobe appears in the very next high phase. The hold-clock address and write data of the finishing cycle are still correct in the clock where the next request is taken.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TW   = 4,
  parameter int NREG = 4,
  parameter int WW   = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [TW-1:0]    req_attr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [RW-1:0]    req_region,
  input  logic [NREG-1:0]  cfg_int_ack,
  input  logic [NREG*WW-1:0] cfg_wait,
  output logic             core_busy,
  output logic             core_done,
  output logic [DW-1:0]    core_rdata,
  output logic             bus_clk,
  output logic             bus_ts_n,
  output logic             bus_as_n,
  output logic             bus_rnw,
  output logic [AW-1:0]    bus_addr,
  output logic [TW-1:0]    bus_attr,
  output logic [DW-1:0]    bus_wdata,
  output logic             bus_data_oe,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ta_n
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR_H, ST_ADDR_L, ST_DATA_H, ST_DATA_L, ST_HOLD_H, ST_HOLD_L
  } state_t;

  state_t         st, st_nx;
  logic           ph;
  logic           wr_q, int_q;
  logic [WW-1:0]  cnt;
  logic [AW-1:0]  addr_q;
  logic [TW-1:0]  attr_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic           take, ack;

  assign core_busy = !(ph && (st == ST_IDLE || st == ST_HOLD_L));
  assign take      = req_valid && !core_busy;
  assign ack       = int_q ? (cnt == '0) : !bus_ta_n;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (take) st_nx = ST_ADDR_H;
      ST_ADDR_H: st_nx = ST_ADDR_L;
      ST_ADDR_L: st_nx = ST_DATA_H;
      ST_DATA_H: st_nx = ST_DATA_L;
      ST_DATA_L: st_nx = ack ? ST_HOLD_H : ST_DATA_H;
      ST_HOLD_H: st_nx = ST_HOLD_L;
      ST_HOLD_L: st_nx = take ? ST_ADDR_H : ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= 1'b0;
      wr_q    <= 1'b0;
      int_q   <= 1'b0;
      cnt     <= '0;
      addr_q  <= '0;
      attr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st <= st_nx;
      ph <= !ph;
      if (take) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        attr_q  <= req_attr;
        wdata_q <= req_wdata;
        int_q   <= cfg_int_ack[req_region];
        cnt     <= cfg_wait[WW*int'(req_region) +: WW];
      end else if (st == ST_DATA_L) begin
        if (!ack && cnt != '0) cnt <= cnt - 1'b1;
        if (ack && !wr_q) rdata_q <= bus_rdata;
      end
    end
  end

  assign bus_clk     = !ph;
  assign bus_ts_n    = !(st == ST_ADDR_H || st == ST_ADDR_L);
  assign bus_as_n    = !(st == ST_ADDR_L || st == ST_DATA_H || st == ST_DATA_L);
  assign bus_data_oe = wr_q && (st == ST_DATA_H || st == ST_DATA_L ||
                                st == ST_HOLD_H || st == ST_HOLD_L);
  assign bus_rnw     = !wr_q;
  assign bus_addr    = addr_q;
  assign bus_attr    = attr_q;
  assign bus_wdata   = wdata_q;
  assign core_done   = (st == ST_HOLD_H);
  assign core_rdata  = rdata_q;

endmodule

module ext_bus_ctrl_chk #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_clk,
  input logic          bus_ts_n,
  input logic          bus_as_n,
  input logic          bus_rnw,
  input logic [AW-1:0] bus_addr,
  input logic [TW-1:0] bus_attr,
  input logic          bus_data_oe,
  input logic          core_busy,
  input logic          core_done
);

  p_clk_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |=> !bus_clk);

  p_ts_high_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ts_n) |-> bus_clk);

  p_ts_two_states_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ts_n) |=> !bus_ts_n);

  p_ts_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ts_n && $past(!bus_ts_n)) |=> bus_ts_n);

  p_as_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> (!bus_clk && !bus_ts_n));

  p_as_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (bus_clk && core_done));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  p_oe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe) |-> (bus_clk && bus_ts_n && !bus_as_n));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n || core_done) |-> ($stable(bus_addr) && $stable(bus_attr) && $stable(bus_rnw)));

  p_busy_ts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ts_n |-> core_busy);

  p_free_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_busy);

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_ts_n(bus_ts_n),
  .bus_as_n(bus_as_n), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
  .bus_attr(bus_attr), .bus_data_oe(bus_data_oe), .core_busy(core_busy),
  .core_done(core_done)
);

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  attr;
    logic [31:0] data;
    logic [1:0]  rgn;
    logic [4:0]  ext;
    logic [4:0]  exp_w;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0000_1000, 4'h1, 32'hDEAD_BEEF, 2'd0, 5'd0,  5'd0},
    '{1'b1, 32'h0000_2004, 4'h2, 32'h1234_5678, 2'd0, 5'd2,  5'd2},
    '{1'b0, 32'h8000_0010, 4'h3, 32'hA5A5_0F0F, 2'd1, 5'd1,  5'd1},
    '{1'b1, 32'hFFFF_FFFC, 4'h7, 32'h0BAD_F00D, 2'd2, 5'd9,  5'd0},
    '{1'b0, 32'h1234_5678, 4'h5, 32'hCAFE_0001, 2'd3, 5'd0,  5'd15},
    '{1'b1, 32'h0000_0000, 4'h0, 32'hFFFF_FFFF, 2'd3, 5'd31, 5'd15},
    '{1'b0, 32'h4000_0000, 4'h8, 32'h0000_0001, 2'd2, 5'd31, 5'd0},
    '{1'b0, 32'h0000_0007, 4'hF, 32'h55AA_55AA, 2'd0, 5'd4,  5'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, bus_rdata = '0;
  logic [3:0]  req_attr = '0;
  logic [1:0]  req_region = '0;
  logic [3:0]  cfg_int_ack = 4'b1100;
  logic [15:0] cfg_wait = {4'd15, 4'd0, 4'd7, 4'd5};
  logic        bus_ta_n = 1'b1;
  logic        core_busy, core_done, bus_clk, bus_ts_n, bus_as_n, bus_rnw, bus_data_oe;
  logic [31:0] core_rdata, bus_addr, bus_wdata;
  logic [3:0]  bus_attr;

  int total = 0, bad = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  ext_bus_ctrl i_ext_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_attr(req_attr), .req_wdata(req_wdata),
    .req_region(req_region), .cfg_int_ack(cfg_int_ack), .cfg_wait(cfg_wait),
    .core_busy(core_busy), .core_done(core_done), .core_rdata(core_rdata),
    .bus_clk(bus_clk), .bus_ts_n(bus_ts_n), .bus_as_n(bus_as_n), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_wdata(bus_wdata),
    .bus_data_oe(bus_data_oe), .bus_rdata(bus_rdata), .bus_ta_n(bus_ta_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input vec_t v, output int stall);
    int n, k;
    bit strobe_ok, drive_ok, busy_ok, oe_ok;
    stall = 0;
    req_write = v.wr; req_addr = v.addr; req_attr = v.attr;
    req_wdata = v.data; req_region = v.rgn; bus_rdata = v.data;
    req_valid = 1'b1;
    while (core_busy) begin @(negedge clk); stall++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; k = 0;
    strobe_ok = 1; drive_ok = 1; busy_ok = 1; oe_ok = 1;
    while (!core_done && n < 100) begin
      if (bus_clk !== (n % 2 == 0)) strobe_ok = 0;
      if (bus_ts_n !== !(n < 2)) strobe_ok = 0;
      if (bus_as_n !== !(n >= 1)) strobe_ok = 0;
      if (bus_addr !== v.addr || bus_attr !== v.attr || bus_rnw !== !v.wr) drive_ok = 0;
      if (bus_data_oe !== (v.wr && n >= 2)) oe_ok = 0;
      if (v.wr && n >= 2 && bus_wdata !== v.data) oe_ok = 0;
      if (!core_busy) busy_ok = 0;
      if (!bus_clk && !bus_as_n) k++;
      bus_ta_n = bus_clk ? 1'b1 : !(k >= 2 + int'(v.ext));
      @(negedge clk);
      n++;
    end
    bus_ta_n = 1'b1;
    chk(strobe_ok, "R3 R4 strobe timing", 0, 0);
    chk(drive_ok, "R9 address/attr/rnw during cycle", bus_addr, v.addr);
    chk(oe_ok, "R8 write data enable", bus_data_oe, v.wr);
    chk(busy_ok && core_busy, "R11 busy during cycle", core_busy, 1);
    chk(n == 4 + 2 * int'(v.exp_w), v.rgn >= 2 ? "R7 internal wait length" :
        (v.exp_w == 0 ? "R5 zero-wait length" : "R6 external wait length"),
        n, 4 + 2 * int'(v.exp_w));
    chk(bus_as_n && bus_ts_n && bus_clk, "R4 strobes at hold clock", {bus_as_n, bus_ts_n, bus_clk}, 3'b111);
    if (!v.wr) chk(core_rdata == v.data, "R5 read data", core_rdata, v.data);
    @(negedge clk);
    chk(!core_done && !core_busy && !bus_clk, "R5 done single phase", {core_done, core_busy, bus_clk}, 0);
    chk(bus_addr == v.addr && bus_data_oe == v.wr && (!v.wr || bus_wdata == v.data),
        "R9 hold clock stability", bus_addr, v.addr);
  endtask

  initial begin
    #(4 * 200000);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st;
    vec_t d;
    repeat (3) @(negedge clk);
    // R1
    chk(bus_ts_n && bus_as_n && !bus_data_oe && !core_done && bus_rnw,
        "R1 idle during reset", {bus_ts_n, bus_as_n, bus_data_oe, core_done, bus_rnw}, 5'b11001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ts_n && bus_as_n && !bus_data_oe && !core_done && bus_rnw,
        "R1 idle after reset", {bus_ts_n, bus_as_n, bus_data_oe, core_done, bus_rnw}, 5'b11001);
    chk(bus_clk == 1'b0, "R2 bus clock low after first edge", bus_clk, 0);
    @(negedge clk);
    chk(bus_clk == 1'b1 && core_busy, "R2 R11 idle high phase busy", {bus_clk, core_busy}, 2'b11);
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i], st);
      if (i == 0) chk(st == 1, "R11 request held in idle high phase", st, 1);
      else chk(st == 0, "R10 back-to-back start", st, 0);
    end
    // R7 mid-range internal count
    cfg_wait[11:8] = 4'd3;
    d = '{1'b1, 32'h0000_0ABC, 4'h9, 32'h3C3C_3C3C, 2'd2, 5'd0, 5'd3};
    xfer(d, st);
    chk(st == 0, "R10 back-to-back after loop", st, 0);
    // R7 external ack held off on internal region has no effect
    d = '{1'b0, 32'h0000_0DEF, 4'h4, 32'h9999_0000, 2'd2, 5'd31, 5'd3};
    xfer(d, st);
    repeat (4) @(negedge clk);
    d = '{1'b1, 32'h0000_1111, 4'h6, 32'h7777_8888, 2'd1, 5'd3, 5'd3};
    if (!bus_clk) @(negedge clk);
    xfer(d, st);
    chk(st == 1, "R11 held off from idle high phase", st, 1);
    d = '{1'b0, 32'h0000_2222, 4'h2, 32'h4444_5555, 2'd0, 5'd0, 5'd0};
    xfer(d, st);
    chk(st == 0, "R10 read after write back-to-back", st, 0);
    repeat (2) @(negedge clk);
    chk(bus_ts_n && bus_as_n && !core_busy == !bus_clk, "R1 return to idle", {bus_ts_n, bus_as_n}, 2'b11);
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule